// File: doc/BRIEF.md
# Bit-Serial Adder with Built-In Arithmetic Right Shift

This block adds two two's-complement operands that arrive one bit per clock, least significant bit first, each word taking `WORD_W` cycles. Before the sum is formed, one operand (the shifted operand) is scaled by an arithmetic right shift of the constant `SHIFT_K`. The other operand (the addend) is either added as it is or negated, depending on the `SUBTRACT` parameter. The result is `(shifted >>> SHIFT_K) + addend` or `(shifted >>> SHIFT_K) - addend`, taken modulo 2^WORD_W.

The shift takes no extra hardware beyond registers. The addend path is delayed by `SHIFT_K` cycles, so each addend bit meets the shifted-operand bit that is `SHIFT_K` positions higher. During the last `SHIFT_K` output slots of a word, the captured sign bit of the shifted operand is replayed instead of new input.

A single full-adder cell does the arithmetic, with one carry flip-flop. The carry is seeded at every word boundary: with 0 for addition, or with 1 for subtraction, where the seed combines with the inverted addend to form the two's complement. A frame strobe marks each input LSB. A copy of that strobe, delayed by the same `SHIFT_K` cycles, marks each output LSB. Words may follow each other with no gap.

Top module: `bit_serial_shift_add`

## Requirements
- R1: With `SUBTRACT`=0, the serial result word equals `(S >>> SHIFT_K) + A` modulo 2^WORD_W. Here A is the word on `addend_bit` and S is the word on `shifted_bit`, both two's complement, bit i sent in the i-th cycle counted from the cycle in which `frame_in` is 1.
- R2: With `SUBTRACT`=1, the serial result word equals `(S >>> SHIFT_K) - A` modulo 2^WORD_W.
- R3: `frame_out` is `frame_in` delayed by exactly `SHIFT_K` cycles. Result bit i (i = 0 .. WORD_W-1) appears on `sum_bit` `SHIFT_K`+i cycles after the input LSB cycle, so it shares its cycle with `frame_out` when i = 0.
- R4: In the top `SHIFT_K` output slots of a word, the sum uses bit WORD_W-1 of the shifted operand. Whatever `shifted_bit` carries in those cycles (the next word or idle values) has no effect on the result.
- R5: The carry is reseeded in every output LSB slot, with 0 for addition and 1 for subtraction. No carry passes from one word into the next.
- R6: The carry out of the MSB slot is discarded, so sums that overflow wrap modulo 2^WORD_W.
- R7: From reset until the first `frame_out` pulse, `sum_bit` and `frame_out` are 0 whatever the serial inputs carry.
- R8: A new word can start every WORD_W cycles with no idle cycle. Idle gaps of any length between words are also accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frame_in | input | 1 | High in the LSB cycle of each input word |
| addend_bit | input | 1 | Serial addend, LSB first; negated when `SUBTRACT`=1 |
| shifted_bit | input | 1 | Serial operand that is arithmetically right-shifted by `SHIFT_K`, LSB first |
| sum_bit | output | 1 | Serial result, LSB first |
| frame_out | output | 1 | High in the LSB cycle of each result word |

## Verification
The hardest case to reach is the overlap at a word boundary. While the last `SHIFT_K` result bits of one word are still being formed, the next word's LSBs are already arriving on `shifted_bit`. In that same stretch, the carry left over from the finished word must be thrown away.

The stimulus sends words back to back. It pairs positive and negative shifted operands so that the bits of the following word differ from the sign that must be replayed. It also places a word that ends with a carry out of the MSB directly before an all-zero word. Random gaps filled with noise on the serial inputs exercise the idle case, and a running behavioural model checks every output bit of both an adding and a subtracting instance.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    // Largest supported constant shift.
    localparam int BSA_MAX_SHIFT = 7;

    typedef enum logic {
        BSA_ADD = 1'b0,
        BSA_SUB = 1'b1
    } bsa_op_e;

    // The three bits that meet in the full-adder cell in one slot.
    typedef struct packed {
        logic addend;
        logic shifted;
        logic carry;
    } bsa_slice_t;

    function automatic logic bsa_sum(input bsa_slice_t s);
        return s.addend ^ s.shifted ^ s.carry;
    endfunction

    function automatic logic bsa_carry(input bsa_slice_t s);
        return (s.addend & s.shifted) | (s.addend & s.carry) | (s.shifted & s.carry);
    endfunction

endpackage

// File: rtl/bsa_delay.sv
module bsa_delay #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_pipe
            logic [DEPTH-1:0] pipe_q;
            logic [3:0]       since_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    pipe_q <= '0;
                end else begin
                    pipe_q[0] <= din;
                    for (int i = 1; i < DEPTH; i++) begin
                        pipe_q[i] <= pipe_q[i-1];
                    end
                end
            end

            assign dout = pipe_q[DEPTH-1];

            // Cycles elapsed since reset, saturating; used only by the check below.
            always_ff @(posedge clk) begin
                if (rst)                 since_q <= '0;
                else if (since_q != 4'hF) since_q <= since_q + 4'd1;
            end

            AST_DELAY_EXACT: assert property (@(posedge clk) disable iff (rst)
                (since_q >= 4'(DEPTH)) |-> (dout == $past(din, DEPTH))); // R3
        end
    endgenerate

endmodule

// File: rtl/bsa_slot_ctrl.sv
module bsa_slot_ctrl #(
    parameter int WORD_W  = 16,
    parameter int SHIFT_K = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic lsb,      // output-side word start
    input  logic b_live,   // shifted operand as it arrives
    output logic b_eff,    // shifted operand after sign replay
    output logic active    // an output word has begun since reset
);

    localparam int SLOT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    typedef logic [SLOT_W-1:0] slot_t;
    localparam slot_t LAST_SLOT = slot_t'(WORD_W - 1);

    slot_t slot_q;
    slot_t slot;
    logic  active_q;

    assign slot   = lsb ? '0 : slot_q;
    assign active = active_q | lsb;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= '0;
            active_q <= 1'b0;
        end else begin
            slot_q   <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
            active_q <= active;
        end
    end

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        lsb |=> (lsb || slot == slot_t'(1))); // R3

    generate
        if (SHIFT_K == 0) begin : g_noshift
            assign b_eff = b_live;
        end else begin : g_shift
            localparam slot_t HOLD_AT    = slot_t'(WORD_W - SHIFT_K);
            localparam slot_t CAPTURE_AT = slot_t'(WORD_W - 1 - SHIFT_K);

            logic sign_q;
            logic hold;

            assign hold  = (slot >= HOLD_AT);
            assign b_eff = hold ? sign_q : b_live;

            // The operand's MSB arrives while the output sits at CAPTURE_AT.
            always_ff @(posedge clk) begin
                if (rst)                      sign_q <= 1'b0;
                else if (slot == CAPTURE_AT)  sign_q <= b_live;
            end

            AST_SIGN_HELD: assert property (@(posedge clk) disable iff (rst)
                hold |=> (!hold || $stable(sign_q))); // R4
        end
    endgenerate

endmodule

// File: rtl/bsa_fa_cell.sv
module bsa_fa_cell
    import bsa_pkg::*;
#(
    parameter bsa_op_e OP = BSA_ADD
) (
    input  logic clk,
    input  logic rst,
    input  logic lsb,
    input  logic a_eff,
    input  logic b_eff,
    output logic sum
);

    logic       carry_q;
    bsa_slice_t slice;

    assign slice.addend  = a_eff;
    assign slice.shifted = b_eff;
    assign slice.carry   = lsb ? (OP == BSA_SUB) : carry_q;
    assign sum           = bsa_sum(slice);

    // Carry out of the MSB slot is overwritten by the next seed.
    always_ff @(posedge clk) begin
        if (rst) carry_q <= 1'b0;
        else     carry_q <= bsa_carry(slice);
    end

    AST_LSB_SEED: assert property (@(posedge clk) disable iff (rst)
        (lsb && (a_eff == b_eff)) |-> (sum == (OP == BSA_SUB))); // R5

endmodule

// File: rtl/bit_serial_shift_add.sv
module bit_serial_shift_add
    import bsa_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int SHIFT_K  = 3,
    parameter bit SUBTRACT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_in,
    input  logic addend_bit,
    input  logic shifted_bit,
    output logic sum_bit,
    output logic frame_out
);

    localparam bsa_op_e OP = SUBTRACT ? BSA_SUB : BSA_ADD;

    generate
        if (SHIFT_K < 0 || SHIFT_K > BSA_MAX_SHIFT || SHIFT_K >= WORD_W || WORD_W < 2) begin : g_bad
            $error("bit_serial_shift_add: unsupported WORD_W/SHIFT_K");
        end
    endgenerate

    logic a_inv;
    logic a_dly;
    logic b_eff;
    logic active;
    logic raw_sum;

    // Inversion sits before the delay so its reset-zero flops feed a zero addend.
    assign a_inv = addend_bit ^ SUBTRACT;

    bsa_delay #(.DEPTH(SHIFT_K)) u_frame_dly (
        .clk  (clk),
        .rst  (rst),
        .din  (frame_in),
        .dout (frame_out)
    );

    bsa_delay #(.DEPTH(SHIFT_K)) u_addend_dly (
        .clk  (clk),
        .rst  (rst),
        .din  (a_inv),
        .dout (a_dly)
    );

    bsa_slot_ctrl #(.WORD_W(WORD_W), .SHIFT_K(SHIFT_K)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .lsb    (frame_out),
        .b_live (shifted_bit),
        .b_eff  (b_eff),
        .active (active)
    );

    bsa_fa_cell #(.OP(OP)) u_cell (
        .clk   (clk),
        .rst   (rst),
        .lsb   (frame_out),
        .a_eff (a_dly),
        .b_eff (b_eff),
        .sum   (raw_sum)
    );

    assign sum_bit = active & raw_sum;

endmodule

// File: tb/test_bit_serial_shift_add.sv
`timescale 1ns/1ps
module test_bit_serial_shift_add;

    localparam int W = 16;
    localparam int K = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_in = 1'b0;
    logic a_in = 1'b0;
    logic b_in = 1'b0;
    logic sum_add, frm_add, sum_sub, frm_sub;

    always #2.5 clk = ~clk;

    bit_serial_shift_add #(.WORD_W(W), .SHIFT_K(K), .SUBTRACT(1'b0)) i_bit_serial_shift_add (
        .clk(clk), .rst(rst), .frame_in(frame_in), .addend_bit(a_in),
        .shifted_bit(b_in), .sum_bit(sum_add), .frame_out(frm_add));

    bit_serial_shift_add #(.WORD_W(W), .SHIFT_K(K), .SUBTRACT(1'b1)) i_bit_serial_shift_add_sub (
        .clk(clk), .rst(rst), .frame_in(frame_in), .addend_bit(a_in),
        .shifted_bit(b_in), .sum_bit(sum_sub), .frame_out(frm_sub));

    typedef struct {
        int cyc;
        bit v_add;
        bit v_sub;
        int req;
    } exp_t;

    exp_t exq[$];
    int   frq[$];
    int   cyc = 0;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 0;
    bit   seen_first = 0;
    int unsigned lcg = 32'h1234_5678;

    function automatic int unsigned rnd();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg >> 8;
    endfunction

    task automatic cmp(input string what, input int req, input logic got, input logic exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s cycle %0d: actual %b expected %b", req, what, cyc, got, exp);
        end
    endtask

    // Reference: result words computed as integers, split into timed bits.
    function automatic void push_word(input int f, input logic [W-1:0] a,
                                      input logic [W-1:0] b, input int req);
        logic signed [W-1:0] bs;
        logic [W-1:0] ya, ys;
        bs = $signed(b) >>> K;
        ya = bs + a;        // R1, R6 wrap by truncation
        ys = bs - a;        // R2
        for (int i = 0; i < W; i++)
            exq.push_back('{f + K + i, ya[i], ys[i], req});
        frq.push_back(f + K);
    endfunction

    task automatic step(input bit fr, input bit a, input bit b);
        bit exp_f;
        @(negedge clk);
        frame_in = fr; a_in = a; b_in = b;
        #1;
        exp_f = (frq.size() > 0 && frq[0] == cyc);
        if (exp_f) begin
            void'(frq.pop_front());
            seen_first = 1;
        end
        cmp("frame_out add", 3, frm_add, exp_f);   // R3
        cmp("frame_out sub", 3, frm_sub, exp_f);   // R3
        if (exq.size() > 0 && exq[0].cyc == cyc) begin
            cmp("sum add", exq[0].req, sum_add, exq[0].v_add);
            cmp("sum sub", (exq[0].req == 1) ? 2 : exq[0].req, sum_sub, exq[0].v_sub);
            void'(exq.pop_front());
        end else if (!seen_first) begin
            cmp("idle sum add", 7, sum_add, 1'b0); // R7
            cmp("idle sum sub", 7, sum_sub, 1'b0); // R7
        end
        cyc++;
    endtask

    task automatic send_word(input logic [W-1:0] a, input logic [W-1:0] b, input int req);
        push_word(cyc, a, b, req);
        for (int i = 0; i < W; i++) step(i == 0, a[i], b[i]);
    endtask

    task automatic idle(input int n, input bit noisy);
        for (int i = 0; i < n; i++) begin
            int unsigned r;
            r = rnd();
            step(1'b0, noisy & r[0], noisy & r[1]);
        end
    endtask

    initial begin
        // R7: reset state with ones on the serial inputs
        a_in = 1'b1; b_in = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        cmp("reset sum add", 7, sum_add, 1'b0);
        cmp("reset sum sub", 7, sum_sub, 1'b0);
        cmp("reset frame", 7, frm_add, 1'b0);
        rst = 1'b0;
        // R7: inputs toggling before any frame
        idle(6, 1'b1);

        // R1/R2 basic values, R3 timing
        send_word(16'd5, 16'd40, 1);
        send_word(16'd100, 16'd8, 1);
        // R4: negative shifted operand followed back to back (R8) by a positive one
        send_word(16'd3, 16'hF000, 4);
        send_word(16'd0, 16'h7FF8, 4);
        send_word(16'd1, 16'h8001, 4);
        send_word(16'h0000, 16'h0000, 4);
        // R6: overflow wraps
        send_word(16'hFFFF, 16'h7FFF, 6);
        send_word(16'h7FFF, 16'h7FF8, 6);
        // R5: carry out of MSB followed by a zero word
        send_word(16'hFFFF, 16'h0008, 5);
        send_word(16'h0000, 16'h0000, 5);
        send_word(16'h8000, 16'h0000, 5);
        send_word(16'h0000, 16'h0000, 5);
        // R8: gap with noise, then more words
        idle(5, 1'b1);
        send_word(16'h1234, 16'hABCD, 8);
        idle(1, 1'b1);
        send_word(16'hFEDC, 16'h4321, 8);

        // Random words, back to back or with noisy gaps (R1, R2, R4, R8)
        for (int n = 0; n < 200; n++) begin
            int unsigned r1, r2, r3;
            r1 = rnd(); r2 = rnd(); r3 = rnd();
            send_word(r1[W-1:0], r2[W-1:0], (n % 2 == 0) ? 1 : 8);
            if (r3 % 5 == 0) idle(int'(r3 % 4) + 1, 1'b1);
        end
        idle(K + 3, 1'b1);
        if (exq.size() != 0 || frq.size() != 0) begin
            n_bad++;
            $display("FAIL R3 pending expectations: actual %0d expected 0", exq.size() + frq.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R8 watchdog expired: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule